// File: doc/BRIEF.md
# Machine Status and Interrupt Control Register Bank

This block holds the trap-related control registers of a small RISC-V style hart: the machine status word, the interrupt-enable and interrupt-pending registers, the two delegation registers and the machine and supervisor trap-vector bases. A write port (address, data, enable) updates them one register per cycle. Every write is legalised field by field before it is stored: read-only and unimplemented bits keep their old value, a previous-mode value that names an unsupported mode is dropped, and the floating-point state field is forced to off or dirty. The summary dirty bit is then derived from the stored fields.

The supervisor status, enable and pending registers are not separate storage. They are masked windows onto the machine registers: the status window exposes a fixed subset of fields, and the interrupt windows expose only the bits delegated through the interrupt delegation register. A write that changes a field used by address translation produces a one-cycle flush pulse for the translation cache. A separate read port returns any register, registered, one cycle after the address is presented. Privilege checks and instruction decode sit in the pipeline around this bank.

Addresses follow the standard RISC-V CSR numbering: machine status 0x300, exception delegation 0x302, interrupt delegation 0x303, machine enable 0x304, machine vector 0x305, machine pending 0x344, supervisor status 0x100, supervisor enable 0x104, supervisor vector 0x105, supervisor pending 0x144.

Top module: `mctl_csr_bank`

## Requirements
- R1: A write to machine status (0x300) changes only bits 1, 3, 5, 7, 8, 11-12, 13-14, 17, 18 and 19 (mask 0x000E79AA); every other bit keeps its value, apart from the derived bit XLEN-1.
- R2: When the previous-mode field (bits 12:11) of the written value is 2, or is 1 with supervisor mode absent, or is 0 with user mode absent, that field keeps its old value while the rest of the write still applies.
- R3: After any status write, a nonzero floating-point state field (bits 14:13) is stored as 2'b11, so the field only ever holds 0 or 3.
- R4: Bit XLEN-1 of machine status is set exactly when bits 14:13 or bits 16:15 equal 2'b11.
- R5: The flush output is high for one cycle, in the cycle after a write, exactly when that write changed any of bits 19, 18, 17 or 12:11 of machine status; it is low otherwise.
- R6: Machine enable keeps only bits 1, 3, 5, 7, 9 (mask 0x2AA); interrupt delegation keeps only bits 1, 5, 9 (mask 0x222); machine pending keeps only bits 1 and 5 (mask 0x22) as writable.
- R7: Supervisor enable and pending read as the machine register ANDed with interrupt delegation; a write to them changes only the bits set in interrupt delegation.
- R8: A vector-base write whose bits 1:0 are nonzero leaves the register unchanged; otherwise the value is stored with bits 1:0 zero.
- R9: Supervisor status reads and writes machine status through the mask of bits 0, 1, 4, 5, 8, 13-16, 18, 19 and XLEN-1 (0x800DE133 at XLEN 32), and a write through it is then legalised as in R1-R4.
- R10: Exception delegation keeps only causes 0 to 13 and 15 (mask 0xBFFF).
- R11: A write to an address outside the listed set raises the bad-address output for one cycle in the next cycle and changes no register; a read of such an address returns zero.
- R12: Reset (synchronous, active high) clears every register except the machine previous-mode field, which becomes 3, so machine status reads 0x1800.
- R13: Read data is registered: it reflects the address presented one cycle earlier and the register contents as of that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write address |
| wr_data | input | XLEN | Write value before legalisation |
| rd_addr | input | 12 | Read address |
| rd_data | output | XLEN | Registered read value |
| tlb_flush | output | 1 | One-cycle translation flush pulse |
| wr_bad | output | 1 | One-cycle pulse after a write to an unknown address |

## Verification
Every result of this bank is due exactly one clock after its stimulus: a write lands in the register and raises the flush and bad-address pulses at the next edge, and read data appears at the edge after the read address is driven. The bench's driver stamps each expected value with that due cycle as it pushes it into the scoreboard queue, and the monitor, sampling on the falling edge, compares only the entries whose stamp matches the current cycle, treating a stale entry as a failure. Writes are followed by reads so that each legalised register value is seen through the read port one cycle after the update edge.

// File: rtl/mctl_pkg.sv
package mctl_pkg;

  localparam int unsigned ADDR_W = 12;
  typedef logic [ADDR_W-1:0] csr_addr_t;

  localparam csr_addr_t A_MSTATUS = 12'h300;
  localparam csr_addr_t A_MEDELEG = 12'h302;
  localparam csr_addr_t A_MIDELEG = 12'h303;
  localparam csr_addr_t A_MIE     = 12'h304;
  localparam csr_addr_t A_MTVEC   = 12'h305;
  localparam csr_addr_t A_MIP     = 12'h344;
  localparam csr_addr_t A_SSTATUS = 12'h100;
  localparam csr_addr_t A_SIE     = 12'h104;
  localparam csr_addr_t A_STVEC   = 12'h105;
  localparam csr_addr_t A_SIP     = 12'h144;

  // status field positions (low 20 bits; the dirty summary is bit XLEN-1)
  localparam int unsigned ST_FS_LO  = 13;
  localparam int unsigned ST_XS_LO  = 15;
  localparam int unsigned ST_MPP_LO = 11;

  localparam logic [19:0] ST_WMASK   = 20'hE79AA; // writable machine fields
  localparam logic [19:0] ST_VMMASK  = 20'hE1800; // translation-relevant fields
  localparam logic [19:0] ST_MPPMASK = 20'h01800;
  localparam logic [19:0] ST_SVMASK  = 20'hDE133; // supervisor window, low part
  localparam logic [9:0]  IRQ_ENMASK = 10'h2AA;
  localparam logic [9:0]  IRQ_DGMASK = 10'h222;
  localparam logic [9:0]  IRQ_PNMASK = 10'h022;
  localparam logic [15:0] EXC_DGMASK = 16'hBFFF;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_MSTATUS, SEL_SSTATUS, SEL_MIE, SEL_SIE, SEL_MIP,
    SEL_SIP, SEL_MIDELEG, SEL_MEDELEG, SEL_MTVEC, SEL_STVEC
  } csr_sel_t;

  function automatic csr_sel_t csr_decode(input csr_addr_t a);
    case (a)
      A_MSTATUS: return SEL_MSTATUS;
      A_SSTATUS: return SEL_SSTATUS;
      A_MIE:     return SEL_MIE;
      A_SIE:     return SEL_SIE;
      A_MIP:     return SEL_MIP;
      A_SIP:     return SEL_SIP;
      A_MIDELEG: return SEL_MIDELEG;
      A_MEDELEG: return SEL_MEDELEG;
      A_MTVEC:   return SEL_MTVEC;
      A_STVEC:   return SEL_STVEC;
      default:   return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/mctl_status_reg.sv
module mctl_status_reg
  import mctl_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter bit          HAS_SMODE = 1'b1,
  parameter bit          HAS_UMODE = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [XLEN-1:0] wval,
  output logic [XLEN-1:0] q,
  output logic            flush
);

  localparam logic [XLEN-1:0] WMASK   = XLEN'(ST_WMASK);
  localparam logic [XLEN-1:0] VMMASK  = XLEN'(ST_VMMASK);
  localparam logic [XLEN-1:0] MPPMASK = XLEN'(ST_MPPMASK);
  localparam logic [XLEN-1:0] RSTVAL  = XLEN'(ST_MPPMASK);
  localparam int unsigned     SD_BIT  = XLEN - 1;

  logic [1:0]      mpp_in;
  logic            mpp_ok;
  logic [XLEN-1:0] mask;
  logic [XLEN-1:0] legal;

  always_comb begin
    mpp_in = wval[ST_MPP_LO +: 2];
    mpp_ok = !((mpp_in == 2'd2) ||
               (mpp_in == 2'd1 && !HAS_SMODE) ||
               (mpp_in == 2'd0 && !HAS_UMODE));
    mask   = mpp_ok ? WMASK : (WMASK & ~MPPMASK);
    legal  = (q & ~mask) | (wval & mask);
    if (legal[ST_FS_LO +: 2] != 2'b00)
      legal[ST_FS_LO +: 2] = 2'b11;
    legal[SD_BIT] = (legal[ST_FS_LO +: 2] == 2'b11) ||
                    (legal[ST_XS_LO +: 2] == 2'b11);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= RSTVAL;
      flush <= 1'b0;
    end else begin
      flush <= we && (((legal ^ q) & VMMASK) != '0);
      if (we)
        q <= legal;
    end
  end

endmodule

// File: rtl/mctl_irq_regs.sv
module mctl_irq_regs
  import mctl_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_mie,
  input  logic            we_sie,
  input  logic            we_mip,
  input  logic            we_sip,
  input  logic            we_mideleg,
  input  logic            we_medeleg,
  input  logic [XLEN-1:0] wval,
  output logic [XLEN-1:0] mie_q,
  output logic [XLEN-1:0] mip_q,
  output logic [XLEN-1:0] mideleg_q,
  output logic [XLEN-1:0] medeleg_q
);

  localparam logic [XLEN-1:0] ENMASK  = XLEN'(IRQ_ENMASK);
  localparam logic [XLEN-1:0] DGMASK  = XLEN'(IRQ_DGMASK);
  localparam logic [XLEN-1:0] PNMASK  = XLEN'(IRQ_PNMASK);
  localparam logic [XLEN-1:0] EXCMASK = XLEN'(EXC_DGMASK);

  logic [XLEN-1:0] en_src, en_msk, pn_src, pn_msk;

  always_comb begin
    // supervisor windows narrow the write to the delegated bits
    en_src = we_sie ? wval : wval;
    en_msk = we_sie ? (ENMASK & mideleg_q) : ENMASK;
    pn_src = wval;
    pn_msk = we_sip ? (PNMASK & mideleg_q) : PNMASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mie_q     <= '0;
      mip_q     <= '0;
      mideleg_q <= '0;
      medeleg_q <= '0;
    end else begin
      if (we_mie || we_sie)
        mie_q <= (mie_q & ~en_msk) | (en_src & en_msk);
      if (we_mip || we_sip)
        mip_q <= (mip_q & ~pn_msk) | (pn_src & pn_msk);
      if (we_mideleg)
        mideleg_q <= wval & DGMASK;
      if (we_medeleg)
        medeleg_q <= wval & EXCMASK;
    end
  end

endmodule

// File: rtl/mctl_tvec_reg.sv
module mctl_tvec_reg #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [XLEN-1:0] wval,
  output logic [XLEN-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (we && (wval[1:0] == 2'b00))
      q <= {wval[XLEN-1:2], 2'b00};
  end

endmodule

// File: rtl/mctl_read_mux.sv
module mctl_read_mux
  import mctl_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  csr_addr_t       rd_addr,
  input  logic [XLEN-1:0] mstatus_q,
  input  logic [XLEN-1:0] mie_q,
  input  logic [XLEN-1:0] mip_q,
  input  logic [XLEN-1:0] mideleg_q,
  input  logic [XLEN-1:0] medeleg_q,
  input  logic [XLEN-1:0] mtvec_q,
  input  logic [XLEN-1:0] stvec_q,
  output logic [XLEN-1:0] rd_data
);

  localparam logic [XLEN-1:0] SVMASK = XLEN'(ST_SVMASK) | (XLEN'(1) << (XLEN - 1));

  logic [XLEN-1:0] rd_next;

  always_comb begin
    case (csr_decode(rd_addr))
      SEL_MSTATUS: rd_next = mstatus_q;
      SEL_SSTATUS: rd_next = mstatus_q & SVMASK;
      SEL_MIE:     rd_next = mie_q;
      SEL_SIE:     rd_next = mie_q & mideleg_q;
      SEL_MIP:     rd_next = mip_q;
      SEL_SIP:     rd_next = mip_q & mideleg_q;
      SEL_MIDELEG: rd_next = mideleg_q;
      SEL_MEDELEG: rd_next = medeleg_q;
      SEL_MTVEC:   rd_next = mtvec_q;
      SEL_STVEC:   rd_next = stvec_q;
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else
      rd_data <= rd_next;
  end

endmodule

// File: rtl/mctl_csr_bank.sv
module mctl_csr_bank
  import mctl_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter bit          HAS_SMODE = 1'b1,
  parameter bit          HAS_UMODE = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [11:0]     wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic [11:0]     rd_addr,
  output logic [XLEN-1:0] rd_data,
  output logic            tlb_flush,
  output logic            wr_bad
);

  localparam logic [XLEN-1:0] SVMASK = XLEN'(ST_SVMASK) | (XLEN'(1) << (XLEN - 1));
  localparam int unsigned     NVEC   = 2;

  csr_sel_t        wsel;
  logic [XLEN-1:0] st_wval;
  logic            st_we;
  logic [XLEN-1:0] mstatus_q, mie_q, mip_q, mideleg_q, medeleg_q;
  logic [XLEN-1:0] mtvec_q, stvec_q;
  logic [XLEN-1:0] vec_q [NVEC];

  always_comb begin
    wsel    = csr_decode(wr_addr);
    st_we   = wr_en && (wsel == SEL_MSTATUS || wsel == SEL_SSTATUS);
    st_wval = (wsel == SEL_SSTATUS) ? ((mstatus_q & ~SVMASK) | (wr_data & SVMASK))
                                    : wr_data;
  end

  mctl_status_reg #(
    .XLEN(XLEN), .HAS_SMODE(HAS_SMODE), .HAS_UMODE(HAS_UMODE)
  ) u_status (
    .clk(clk), .rst(rst), .we(st_we), .wval(st_wval),
    .q(mstatus_q), .flush(tlb_flush)
  );

  mctl_irq_regs #(.XLEN(XLEN)) u_irq (
    .clk(clk), .rst(rst),
    .we_mie(wr_en && wsel == SEL_MIE),
    .we_sie(wr_en && wsel == SEL_SIE),
    .we_mip(wr_en && wsel == SEL_MIP),
    .we_sip(wr_en && wsel == SEL_SIP),
    .we_mideleg(wr_en && wsel == SEL_MIDELEG),
    .we_medeleg(wr_en && wsel == SEL_MEDELEG),
    .wval(wr_data),
    .mie_q(mie_q), .mip_q(mip_q), .mideleg_q(mideleg_q), .medeleg_q(medeleg_q)
  );

  // index 0: machine vector, index 1: supervisor vector
  for (genvar g = 0; g < NVEC; g++) begin : g_vec
    localparam csr_sel_t VSEL = (g == 0) ? SEL_MTVEC : SEL_STVEC;
    mctl_tvec_reg #(.XLEN(XLEN)) u_vec (
      .clk(clk), .rst(rst), .we(wr_en && wsel == VSEL),
      .wval(wr_data), .q(vec_q[g])
    );
  end

  assign mtvec_q = vec_q[0];
  assign stvec_q = vec_q[1];

  mctl_read_mux #(.XLEN(XLEN)) u_rd (
    .clk(clk), .rst(rst), .rd_addr(rd_addr),
    .mstatus_q(mstatus_q), .mie_q(mie_q), .mip_q(mip_q),
    .mideleg_q(mideleg_q), .medeleg_q(medeleg_q),
    .mtvec_q(mtvec_q), .stvec_q(stvec_q), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst)
      wr_bad <= 1'b0;
    else
      wr_bad <= wr_en && (wsel == SEL_NONE);
  end

endmodule

// File: rtl/mctl_csr_bank_chk.sv
module mctl_csr_bank_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic            wr_bad,
  input logic            tlb_flush,
  input logic [XLEN-1:0] mstatus_q,
  input logic [XLEN-1:0] mie_q,
  input logic [XLEN-1:0] mideleg_q,
  input logic [XLEN-1:0] mtvec_q,
  input logic [XLEN-1:0] stvec_q
);

  localparam logic [XLEN-1:0] VMMASK = XLEN'(20'hE1800);
  localparam logic [XLEN-1:0] ENMASK = XLEN'(10'h2AA);
  localparam logic [XLEN-1:0] DGMASK = XLEN'(10'h222);

  assert_mpp_never_two_R2: assert property (@(posedge clk) disable iff (rst)
    mstatus_q[12:11] != 2'b10);

  assert_fs_off_or_dirty_R3: assert property (@(posedge clk) disable iff (rst)
    (mstatus_q[14:13] == 2'b00) || (mstatus_q[14:13] == 2'b11));

  assert_sd_summary_R4: assert property (@(posedge clk) disable iff (rst)
    mstatus_q[XLEN-1] == ((mstatus_q[14:13] == 2'b11) || (mstatus_q[16:15] == 2'b11)));

  assert_flush_on_change_R5: assert property (@(posedge clk) disable iff (rst)
    ((mstatus_q & VMMASK) != ($past(mstatus_q) & VMMASK)) |-> tlb_flush);

  assert_flush_after_write_R5: assert property (@(posedge clk) disable iff (rst)
    tlb_flush |-> $past(wr_en));

  assert_irq_masks_R6: assert property (@(posedge clk) disable iff (rst)
    ((mie_q & ~ENMASK) == '0) && ((mideleg_q & ~DGMASK) == '0));

  assert_vec_aligned_R8: assert property (@(posedge clk) disable iff (rst)
    (mtvec_q[1:0] == 2'b00) && (stvec_q[1:0] == 2'b00));

  assert_bad_write_no_change_R11: assert property (@(posedge clk) disable iff (rst)
    wr_bad |-> ($stable(mstatus_q) && $stable(mie_q) && $stable(mideleg_q) &&
                $stable(mtvec_q) && $stable(stvec_q)));

endmodule

bind mctl_csr_bank mctl_csr_bank_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bad(wr_bad), .tlb_flush(tlb_flush),
  .mstatus_q(mstatus_q), .mie_q(mie_q), .mideleg_q(mideleg_q),
  .mtvec_q(mtvec_q), .stvec_q(stvec_q)
);

// File: tb/tb_mctl_csr_bank.sv
`timescale 1ns/1ps
module tb_mctl_csr_bank;

  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic [11:0]     wr_addr = '0;
  logic [XLEN-1:0] wr_data = '0;
  logic [11:0]     rd_addr = '0;
  logic [XLEN-1:0] rd_data;
  logic            tlb_flush;
  logic            wr_bad;

  always #2 clk = ~clk; // 250 MHz

  mctl_csr_bank #(.XLEN(XLEN)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tlb_flush(tlb_flush), .wr_bad(wr_bad)
  );

  typedef struct {
    int          due;
    int          kind;   // 0 read data, 1 flush, 2 bad address
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int    cyc = 0;
  int    checks = 0;
  int    failures = 0;
  bit    ended = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares every entry due this cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      act = (it.kind == 0) ? rd_data : (it.kind == 1) ? {31'b0, tlb_flush} : {31'b0, wr_bad};
      checks++;
      if (it.due != cyc) begin
        failures++;
        $display("FAIL %s stale entry: act=%h exp=%h", it.tag, act, it.exp);
      end else if (act !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d act=%h exp=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.due = cyc + 1; it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d,
                    input logic fl, input logic bad, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    push(1, {31'b0, fl}, {tag, " flush"});
    push(2, {31'b0, bad}, {tag, " bad"});
  endtask

  // R13: read data is due one cycle after the address is driven
  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    wr_en = 1'b0; rd_addr = a;
    push(0, exp, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R12 reset state, R13 registered read
    rd(12'h300, 32'h0000_1800, "R12 mstatus reset");
    rd(12'h304, 32'h0, "R12 mie reset");
    rd(12'h303, 32'h0, "R12 mideleg reset");
    rd(12'h302, 32'h0, "R12 medeleg reset");
    rd(12'h305, 32'h0, "R12 mtvec reset");
    rd(12'h105, 32'h0, "R12 stvec reset");
    rd(12'h344, 32'h0, "R12 mip reset");

    // R1 writable fields, R4 summary bit, R5 flush
    wr(12'h300, 32'hFFFF_FFFF, 1'b1, 1'b0, "R1 R5 mstatus all ones");
    rd(12'h300, 32'h800E_79AA, "R1 R4 mstatus after all ones");
    rd(12'h100, 32'h800C_6122, "R9 sstatus read window");

    // R2 reserved previous mode dropped, rest applied
    wr(12'h300, 32'h0000_1000, 1'b1, 1'b0, "R2 R5 mstatus mpp=2");
    rd(12'h300, 32'h0000_1800, "R2 mpp kept, other fields cleared");
    wr(12'h300, 32'h0000_0800, 1'b1, 1'b0, "R5 mpp to supervisor");
    rd(12'h300, 32'h0000_0800, "R2 supervisor mpp accepted");
    wr(12'h300, 32'h0000_0800, 1'b0, 1'b0, "R5 no change no flush");

    // R3 FS forced to dirty, R4 SD follows
    wr(12'h300, 32'h0000_2800, 1'b0, 1'b0, "R3 fs=01 write");
    rd(12'h300, 32'h8000_6800, "R3 R4 fs dirty and sd set");
    wr(12'h300, 32'h0000_4800, 1'b0, 1'b0, "R3 fs=10 write");
    rd(12'h300, 32'h8000_6800, "R3 fs=10 stored as dirty");
    wr(12'h300, 32'h0000_0800, 1'b0, 1'b0, "R3 fs off write");
    rd(12'h300, 32'h0000_0800, "R3 R4 fs off sd clear");

    // R9 write through supervisor window
    wr(12'h300, 32'hFFFF_FFFF, 1'b1, 1'b0, "R5 mstatus all ones again");
    wr(12'h100, 32'h0000_0000, 1'b1, 1'b0, "R9 R5 sstatus clear");
    rd(12'h300, 32'h0002_1888, "R9 machine-only fields kept");

    // R6 masks
    wr(12'h304, 32'hFFFF_FFFF, 1'b0, 1'b0, "R6 mie write");
    rd(12'h304, 32'h0000_02AA, "R6 mie mask");
    wr(12'h303, 32'hFFFF_FFFF, 1'b0, 1'b0, "R6 mideleg write");
    rd(12'h303, 32'h0000_0222, "R6 mideleg mask");
    rd(12'h104, 32'h0000_0222, "R7 sie window");

    // R7 supervisor enable write limited by delegation
    wr(12'h303, 32'h0000_0002, 1'b0, 1'b0, "R6 mideleg ssip only");
    wr(12'h104, 32'h0000_0000, 1'b0, 1'b0, "R7 sie clear");
    rd(12'h304, 32'h0000_02A8, "R7 only delegated enable bit cleared");
    rd(12'h104, 32'h0000_0000, "R7 sie reads zero");

    // R6 pending mask, R7 sip window
    wr(12'h344, 32'hFFFF_FFFF, 1'b0, 1'b0, "R6 mip write");
    rd(12'h344, 32'h0000_0022, "R6 mip mask");
    rd(12'h144, 32'h0000_0002, "R7 sip window");
    wr(12'h144, 32'h0000_0000, 1'b0, 1'b0, "R7 sip clear");
    rd(12'h344, 32'h0000_0020, "R7 only delegated pending bit cleared");
    rd(12'h144, 32'h0000_0000, "R7 sip reads zero");

    // R8 vector bases
    wr(12'h305, 32'h0000_1001, 1'b0, 1'b0, "R8 mtvec mode 1");
    rd(12'h305, 32'h0000_0000, "R8 mtvec unchanged");
    wr(12'h305, 32'h8000_0100, 1'b0, 1'b0, "R8 mtvec aligned");
    rd(12'h305, 32'h8000_0100, "R8 mtvec stored");
    wr(12'h305, 32'h8000_0202, 1'b0, 1'b0, "R8 mtvec mode 2");
    rd(12'h305, 32'h8000_0100, "R8 mtvec kept");
    wr(12'h105, 32'h0000_4000, 1'b0, 1'b0, "R8 stvec aligned");
    wr(12'h105, 32'h0000_0003, 1'b0, 1'b0, "R8 stvec mode 3");
    rd(12'h105, 32'h0000_4000, "R8 stvec kept");

    // R10 exception delegation
    wr(12'h302, 32'hFFFF_FFFF, 1'b0, 1'b0, "R10 medeleg write");
    rd(12'h302, 32'h0000_BFFF, "R10 medeleg mask");

    // R11 unknown address
    wr(12'h7C0, 32'hFFFF_FFFF, 1'b0, 1'b1, "R11 unknown write");
    rd(12'h300, 32'h0002_1888, "R11 mstatus untouched");
    rd(12'h304, 32'h0000_02A8, "R11 mie untouched");
    rd(12'h7C0, 32'h0000_0000, "R11 unknown read");

    idle(4);
    finish_run();
  end

endmodule